// File: doc/BRIEF.md
# Configurable Synchronous Serial Port

This block moves one byte at a time over a three-wire clocked serial link: a data input, a data output and a clock pin that it either drives or receives. As master it makes the serial clock itself by dividing the system clock, drives it out and runs exactly eight clock pulses for each transfer. As slave it takes the clock from an external master, passes the clock, data and select lines through two-stage synchronisers, and detects edges in the system clock domain. The transmit byte and the received byte share one transfer, so every frame is a full-duplex exchange.

Software sets everything through a small register port. A control register chooses the role, the bit order, the idle level of the clock and whether input data is sampled on the same edge that changes the output or on the opposite edge. A fourth, optional pin can be enabled for slave use, either as a ready output that tells the master a byte is loaded, or as an active-low select input that gates the clock edges. A done flag reports the end of each frame.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the control register reads 0 (slave, LSB first, idle-low clock, same-edge sampling, fourth pin off), the status reads 0, `sck_o` is low, and `sck_oe`, `aux_oe`, `aux_o` and `done_o` are 0.
- R2: Address 0 holds the control bits and reads back what was written: bit 0 master, bit 1 MSB first, bit 2 sample on the trailing edge, bit 3 clock idles high, bit 4 fourth pin enabled, bit 5 fourth pin is a select input (0: ready output); bits 7..6 read 0. Address 1 writes the transmit byte and reads the received byte; address 2 starts a frame when bit 0 is written as 1 and reads bit 0 done, bit 1 busy.
- R3: As master, `sck_oe` is 1, the clock rests at the idle level set by bit 3, and a start produces exactly 16 clock changes, the first one HALF_DIV cycles after the start write and each following one HALF_DIV cycles later.
- R4: The output bit changes only on the leading edge (the edge away from the idle level); the first bit is on `sdo` before the first edge, and the byte sent equals the byte loaded.
- R5: With bit 2 at 0 the input is sampled on each leading edge; with bit 2 at 1 it is sampled on each trailing edge.
- R6: With bit 1 at 1 the first bit sent and received is bit 7; with bit 1 at 0 it is bit 0.
- R7: Writing start clears done; done sets and busy clears on the eighth trailing edge.
- R8: As slave, `sck_oe` is 0 and a frame clocked by an external master through `sck_i` exchanges the loaded byte with the byte the master sends; edges that arrive while no frame is armed are not counted.
- R9: With the fourth pin enabled as ready output in slave mode, `aux_oe` is 1 and `aux_o` is high from arming until the first leading edge arrives, then low.
- R10: With the fourth pin enabled as select input in slave mode, clock edges that arrive while `aux_i` is high are ignored: the frame stays busy and the received byte is unchanged.
- R11: With the fourth pin disabled, `aux_oe` and `aux_o` stay 0 and `aux_i` has no effect on transfers.
- R12: While a frame is busy, writes to the control register, the transmit byte and the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for reg_addr |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Drive enable for the clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| aux_i | input | 1 | Fourth pin input, active-low select |
| aux_o | output | 1 | Fourth pin output, ready when high |
| aux_oe | output | 1 | Drive enable for the fourth pin |
| done_o | output | 1 | Frame-complete flag |

## Verification
Master frames run through all eight combinations of bit order, idle level and sampling edge, each with a different byte pair; a wrong edge choice shows as a shifted or duplicated bit, and a wrong order shows as a mirrored byte. The clock pin is compared with a count-based model on every cycle, which separates a wrong half period from a wrong pulse count. Slave frames are driven by a behavioural master with slow edges that change data together with the clock, so a design sampling after the edge instead of before it receives the wrong bits; separate runs show ready timing, select gating and writes during a frame.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_CMD  = 2'd2;

  typedef struct packed {
    logic pin_role;  // 1: select input, 0: ready output
    logic pin_en;    // fourth pin enabled
    logic pol;       // clock idle level
    logic late;      // sample on trailing edge
    logic msb;       // MSB first
    logic master;    // 1: master, 0: slave
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ssp_regs.sv
module ssp_regs
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_byte,
  output ctrl_t             ctrl,
  output logic              load,
  output logic [DATA_W-1:0] load_byte,
  output logic              start,
  output logic [DATA_W-1:0] rdata
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (we && addr == ADDR_CTRL && !busy) begin
      ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  always_comb begin
    load      = we && (addr == ADDR_DATA) && !busy;
    load_byte = wdata;
    start     = we && (addr == ADDR_CMD) && wdata[0] && !busy;
    ctrl      = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        ADDR_CTRL: rdata <= {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        ADDR_DATA: rdata <= rx_byte;
        ADDR_CMD:  rdata <= {{(DATA_W-2){1'b0}}, busy, done};
        default:   rdata <= '0;
      endcase
    end
  end

  // control bits must not move while a frame runs
  assert_ctrl_frozen_R12: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ctrl_q));
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic master,
  input  logic pol,
  input  logic sel_en,
  input  logic start,
  input  logic sck_i,
  input  logic sdi,
  input  logic sel_n_i,
  output logic lead,
  output logic trail,
  output logic sdi_smp,
  output logic sck_o,
  output logic sck_oe
);
  localparam int TMR_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int TOGGLES = 2 * DATA_W;
  localparam int TOG_W   = $clog2(TOGGLES + 1);

  // master clock generator
  logic             run;
  logic [TMR_W-1:0] tmr;
  logic [TOG_W-1:0] tog;
  logic             sck_q;
  logic             tmr_end;

  assign tmr_end = (tmr == TMR_W'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      tmr   <= '0;
      tog   <= '0;
      sck_q <= 1'b0;
    end else if (!run) begin
      tmr   <= '0;
      tog   <= '0;
      sck_q <= pol;
      if (start && master) run <= 1'b1;
    end else if (tmr_end) begin
      tmr   <= '0;
      sck_q <= ~sck_q;
      tog   <= tog + 1'b1;
      if (tog == TOG_W'(TOGGLES - 1)) run <= 1'b0;
    end else begin
      tmr <= tmr + 1'b1;
    end
  end

  // slave synchronisers; data carries one extra stage so it lines up
  // with the clock sample taken before the detected edge
  logic sck_m, sck_s, sck_p;
  logic sdi_m, sdi_s, sdi_p;
  logic sel_m, sel_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      {sck_m, sck_s, sck_p} <= '0;
      {sdi_m, sdi_s, sdi_p} <= '0;
      {sel_m, sel_s}        <= 2'b11;
    end else begin
      sck_m <= sck_i;  sck_s <= sck_m;  sck_p <= sck_s;
      sdi_m <= sdi;    sdi_s <= sdi_m;  sdi_p <= sdi_s;
      sel_m <= sel_n_i; sel_s <= sel_m;
    end
  end

  logic sl_edge, sl_gate;
  assign sl_edge = sck_s ^ sck_p;
  assign sl_gate = !master && (!sel_en || !sel_s);

  always_comb begin
    if (master) begin
      lead    = run && tmr_end && !tog[0];
      trail   = run && tmr_end &&  tog[0];
      sdi_smp = sdi;
    end else begin
      lead    = sl_edge && sl_gate && (sck_s != pol);
      trail   = sl_edge && sl_gate && (sck_s == pol);
      sdi_smp = sdi_p;
    end
  end

  assign sck_o  = sck_q;
  assign sck_oe = master;

  // the master clock holds its level for a whole half period
  assert_half_period_R3: assert property (@(posedge clk) disable iff (rst)
    (run && !tmr_end) |=> $stable(sck_q));
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msb,
  input  logic              late,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              start,
  input  logic              lead,
  input  logic              trail,
  input  logic              sdi_smp,
  output logic              sdo,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              first_pending
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] tx_q, rx_q, tx_nxt, rx_nxt;
  logic [CNT_W-1:0]  lcnt, tcnt;
  logic              adv;

  always_comb begin
    if (msb) begin
      tx_nxt = {tx_q[DATA_W-2:0], 1'b0};
      rx_nxt = {rx_q[DATA_W-2:0], sdi_smp};
    end else begin
      tx_nxt = {1'b0, tx_q[DATA_W-1:1]};
      rx_nxt = {sdi_smp, rx_q[DATA_W-1:1]};
    end
    // output moves on leading edges; which ones depends on the sample edge
    adv = late ? (lcnt != '0) : (lcnt != CNT_W'(DATA_W - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_q <= '0;
      lcnt <= '0;
      tcnt <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      if (load) tx_q <= load_byte;
      if (start) begin
        busy <= 1'b1;
        done <= 1'b0;
        lcnt <= '0;
        tcnt <= '0;
      end else if (busy) begin
        if (lead) begin
          lcnt <= lcnt + 1'b1;
          if (!late) rx_q <= rx_nxt;
          if (adv)   tx_q <= tx_nxt;
        end
        if (trail) begin
          tcnt <= tcnt + 1'b1;
          if (late) rx_q <= rx_nxt;
          if (tcnt == CNT_W'(DATA_W - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  assign sdo           = msb ? tx_q[DATA_W-1] : tx_q[0];
  assign rx_byte       = rx_q;
  assign first_pending = busy && (lcnt == '0);

  // never both edges in one cycle
  assert_one_edge_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lead, trail}));
  // done appears only as the result of a trailing edge
  assert_done_on_trail_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(trail));
  // output data is held between leading edges
  assert_sdo_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !lead) |=> $stable(sdo));
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sdi,
  output logic              sdo,
  input  logic              aux_i,
  output logic              aux_o,
  output logic              aux_oe,
  output logic              done_o
);
  ctrl_t             ctrl;
  logic              load, start, busy, done, lead, trail, sdi_smp, first_pending;
  logic [DATA_W-1:0] load_byte, rx_byte;
  logic              ready_role, aux_q;

  ssp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .done(done), .rx_byte(rx_byte), .ctrl(ctrl),
    .load(load), .load_byte(load_byte), .start(start), .rdata(reg_rdata)
  );

  ssp_clkgen #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .master(ctrl.master), .pol(ctrl.pol),
    .sel_en(ctrl.pin_en && ctrl.pin_role), .start(start),
    .sck_i(sck_i), .sdi(sdi), .sel_n_i(aux_i),
    .lead(lead), .trail(trail), .sdi_smp(sdi_smp),
    .sck_o(sck_o), .sck_oe(sck_oe)
  );

  ssp_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .msb(ctrl.msb), .late(ctrl.late),
    .load(load), .load_byte(load_byte), .start(start),
    .lead(lead), .trail(trail), .sdi_smp(sdi_smp),
    .sdo(sdo), .busy(busy), .done(done), .rx_byte(rx_byte),
    .first_pending(first_pending)
  );

  assign ready_role = ctrl.pin_en && !ctrl.master && !ctrl.pin_role;

  always_ff @(posedge clk) begin
    if (rst) aux_q <= 1'b0;
    else     aux_q <= ready_role && first_pending;
  end

  assign aux_o  = aux_q;
  assign aux_oe = ready_role;
  assign done_o = done;

  // ready drops two cycles after the first leading edge is seen
  assert_ready_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (lead && first_pending) |=> ##1 !aux_o);
  // a disabled fourth pin never drives high
  assert_pin_off_R11: assert property (@(posedge clk) disable iff (rst)
    !ctrl.pin_en |=> !aux_o);
endmodule

// File: tb/sync_serial_port_tb.sv
`timescale 1ns/1ps
module sync_serial_port_tb;
  localparam int H  = 4;
  localparam int SH = 8;
  localparam int WD = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       sck_i = 1'b0, sdi = 1'b0, aux_i = 1'b1;
  logic       sck_o, sck_oe, sdo, aux_o, aux_oe, done_o;

  int total = 0;
  int bad   = 0;
  logic [7:0] last_rx = 8'h00;

  always #2.5 clk = ~clk;

  sync_serial_port #(.DATA_W(8), .HALF_DIV(H)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_i(sck_i),
    .sck_o(sck_o), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo),
    .aux_i(aux_i), .aux_o(aux_o), .aux_oe(aux_oe), .done_o(done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  function automatic logic getb(input logic [7:0] b, input int i, input logic msb);
    return msb ? b[7-i] : b[i];
  endfunction

  function automatic int pos(input int i, input logic msb);
    return msb ? 7 - i : i;
  endfunction

  // DUT as master; the bench plays an external slave and models the clock
  task automatic master_xfer(input logic msb, late, pol, input logic [7:0] tx, pb);
    int n_s = 0, n_l = 0, idx = 0, tog = 0, t;
    logic [7:0] prx = 8'h00;
    logic [7:0] v;
    logic psck, psdo;
    wr(2'd0, {4'b0001 & 4'b0000, pol, late, msb, 1'b1});
    wr(2'd1, tx);
    sdi = getb(pb, 0, msb);
    @(negedge clk);
    chk("R3 idle level", sck_o, pol);
    chk("R3 clock drive enable", sck_oe, 1);
    psck = sck_o; psdo = sdo;
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h01;
    for (int k = 1; k <= 16 * H + 2; k++) begin
      @(negedge clk);
      reg_we = 1'b0;
      if (k == 1) chk("R7 done cleared by start", done_o, 0);
      t = (k - 1) / H;
      if (t > 16) t = 16;
      chk("R3 clock waveform", sck_o, pol ^ t[0]);
      if (sck_o != psck) begin
        tog++;
        if (sck_o != pol) begin
          n_l++;
          if (!late) begin
            prx[pos(n_s, msb)] = psdo; n_s++;
            if (n_l <= 7) begin idx++; sdi = getb(pb, idx, msb); end
          end else if (n_l >= 2) begin
            idx++; sdi = getb(pb, idx, msb);
          end
        end else if (late) begin
          prx[pos(n_s, msb)] = psdo; n_s++;
        end
      end
      psck = sck_o; psdo = sdo;
    end
    chk("R3 sixteen clock changes", tog, 16);
    chk("R7 done after frame", done_o, 1);
    rd(2'd1, v);
    chk("R5 R6 master received byte", v, pb);
    chk("R4 R6 master sent byte", prx, tx);
    rd(2'd2, v);
    chk("R7 status done not busy", v, 1);
    last_rx = pb;
  endtask

  // bench as external master clocking the DUT slave
  task automatic drive_frame(input logic msb, late, pol, input logic [7:0] mb,
                             input logic chk_rdy, output logic [7:0] mrx);
    mrx = 8'h00;
    sdi = getb(mb, 0, msb);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!late) mrx[pos(i, msb)] = sdo;
      sck_i = ~pol;
      if (!late && i < 7) sdi = getb(mb, i + 1, msb);
      else if (late && i >= 1) sdi = getb(mb, i, msb);
      repeat (SH) @(negedge clk);
      if (chk_rdy && i == 0) chk("R9 ready low after first edge", aux_o, 0);
      if (late) mrx[pos(i, msb)] = sdo;
      sck_i = pol;
      repeat (SH - 1) @(negedge clk);
    end
    repeat (SH) @(negedge clk);
  endtask

  // mode 0 plain, 1 writes while busy, 2 select blocked first
  task automatic slave_xfer(input logic msb, late, pol, pin_en, role,
                            input logic [7:0] tx, mb, input int mode);
    logic [7:0] ctl, v, mrx, junk;
    logic rdy;
    ctl = {2'b00, role, pin_en, pol, late, msb, 1'b0};
    rdy = pin_en && !role;
    sck_i = pol;
    aux_i = (pin_en && role) ? 1'b0 : 1'b1;
    wr(2'd0, ctl);
    wr(2'd1, tx);
    repeat (4) @(negedge clk);
    wr(2'd2, 8'h01);
    repeat (2) @(negedge clk);
    chk("R8 slave does not drive clock", sck_oe, 0);
    chk("R9 R11 fourth pin enable", aux_oe, rdy);
    chk("R9 R11 ready level after arming", aux_o, rdy);
    if (mode == 1) begin
      wr(2'd0, ctl | 8'h01);
      wr(2'd1, ~tx);
      wr(2'd2, 8'h01);
      rd(2'd0, v);
      chk("R12 control write ignored while busy", v, ctl);
    end
    if (mode == 2) begin
      aux_i = 1'b1;
      drive_frame(msb, late, pol, 8'h3C, 1'b0, junk);
      rd(2'd2, v);
      chk("R10 deselected edges leave frame busy", v, 2);
      rd(2'd1, v);
      chk("R10 deselected edges leave rx unchanged", v, last_rx);
      aux_i = 1'b0;
      repeat (4) @(negedge clk);
    end
    drive_frame(msb, late, pol, mb, rdy, mrx);
    chk("R7 R8 slave done", done_o, 1);
    rd(2'd1, v);
    chk("R5 R6 R8 slave received byte", v, mb);
    chk("R4 R6 R8 slave sent byte", mrx, tx);
    if (!pin_en) chk("R11 pin output stays low", aux_o, 0);
    last_rx = mb;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 clock low", sck_o, 0);
    chk("R1 clock not driven", sck_oe, 0);
    chk("R1 fourth pin off", aux_oe, 0);
    chk("R1 ready low", aux_o, 0);
    chk("R1 done low", done_o, 0);
    rd(2'd0, v); chk("R1 control zero", v, 0);
    rd(2'd2, v); chk("R1 status zero", v, 0);
    // R2 readback
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 control readback all", v, 8'h3F);
    wr(2'd0, 8'h15); rd(2'd0, v); chk("R2 control readback mixed", v, 8'h15);
    wr(2'd0, 8'h00);
    // master frames, all combinations
    for (int c = 0; c < 8; c++) begin
      master_xfer(c[0], c[1], c[2], 8'hA1 + 8'(c * 23), 8'h4E ^ 8'(c * 37));
    end
    // slave frames, fourth pin disabled, aux_i high has no effect
    slave_xfer(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3, 8'h5A, 0);
    slave_xfer(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h96, 8'h0F, 0);
    slave_xfer(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h71, 8'hE8, 0);
    slave_xfer(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h2D, 8'hB4, 0);
    // ready output
    slave_xfer(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h81, 8'h66, 0);
    // writes while busy
    slave_xfer(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h39, 8'hD2, 1);
    // select input gating
    slave_xfer(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hE1, 8'h17, 2);
    finish_run();
  end
endmodule